// File: doc/BRIEF.md
# Shared-Threshold ADC Result Comparator

This block watches the result stream of a four-channel converter and decides, for each finished conversion, whether the owning channel should raise its interrupt flag and emit an event pulse. All channels are measured against one common 12-bit threshold register. Each channel has its own mode. It can fire only on results at or above the threshold, or only on results strictly below it. With comparison switched off, it fires on every result.

Software writes the threshold and the per-channel mode bits through a small write port, and clears flags by writing ones. Results arrive as a valid strobe with a channel index, a 12-bit value and a flag that marks the value as an 8-bit conversion. An 8-bit value is zero-extended before it is compared.

Top module: `adc_thresh_cmp`

## Requirements
- R1: After reset the threshold is 0, every channel has comparison disabled with "below" selected, and all `irq_flag` and `evt_pulse` bits are 0.
- R2: A cycle with `thr_we`=1 loads `thr_wdata` into the single threshold, which every channel uses from the next cycle on.
- R3: With comparison enabled and `mode_above`=1, a result fires its channel when the value is greater than or equal to the threshold, and does not fire it otherwise.
- R4: With comparison enabled and `mode_above`=0, a result fires its channel when the value is strictly less than the threshold, and does not fire it otherwise.
- R5: With comparison disabled, every result fires its channel, whatever its value.
- R6: Firing a channel sets its `irq_flag` bit and drives its `evt_pulse` bit high for exactly the one cycle after the cycle of the result strobe. A result that does not fire leaves both unchanged.
- R7: An `irq_flag` bit stays set until a cycle with the matching `irq_clr` bit at 1 clears it. If the channel fires in that same cycle, the flag stays set.
- R8: When a threshold write and a result share a cycle, the result is compared against the threshold held before the write.
- R9: With `res_narrow`=1, only `res_data[7:0]` is used, and it is zero-extended to 12 bits before the comparison.
- R10: A result affects only the channel given by `res_ch` (0 to 3). The flags and events of the other channels do not change.
- R11: A cycle with `mode_we`=1 loads `mode_en` (1 = comparison enabled) and `mode_above` into channel `mode_ch`. The new mode applies to results from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| thr_we | input | 1 | Threshold write strobe |
| thr_wdata | input | 12 | New threshold value |
| mode_we | input | 1 | Channel mode write strobe |
| mode_ch | input | 2 | Channel whose mode is written |
| mode_en | input | 1 | 1 = compare enabled, 0 = fire on every result |
| mode_above | input | 1 | 1 = fire at or above threshold, 0 = fire below |
| res_valid | input | 1 | Conversion result strobe |
| res_ch | input | 2 | Channel owning the result |
| res_narrow | input | 1 | Result is 8-bit (use bits 7:0, zero-extended) |
| res_data | input | 12 | Conversion result |
| irq_clr | input | 4 | Write-one-to-clear for the interrupt flags |
| irq_flag | output | 4 | Sticky per-channel interrupt flags |
| evt_pulse | output | 4 | One-cycle per-channel event pulses |

## Verification
Every result has one register stage to its outputs. A strobe sampled at edge N shows as `evt_pulse` and a set `irq_flag` right after edge N and is gone from `evt_pulse` after edge N+1. Threshold and mode writes also act at the edge that samples them, so they apply to results from the following cycle. The bench drives inputs on the falling edge and computes the expected next state from the inputs it has just applied. It then samples the outputs at the following falling edge, one full register stage later. Random traffic mixes writes, clears and results in the same cycle, so same-cycle ordering (R7, R8) is exercised alongside directed boundary values at the threshold.

// File: rtl/adc_cmp_pkg.sv
package adc_cmp_pkg;

   typedef struct packed {
      logic en;     // 1 = compare against threshold, 0 = always fire
      logic above;  // 1 = fire on value >= threshold, 0 = fire on value < threshold
   } ch_mode_t;

   localparam ch_mode_t MODE_RESET = '{en: 1'b0, above: 1'b0};

endpackage

// File: rtl/adc_cmp_cfg.sv
module adc_cmp_cfg
   import adc_cmp_pkg::*;
#(
   parameter int NUM_CH = 4,
   parameter int RES_W  = 12,
   localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    thr_we,
   input  logic [RES_W-1:0]        thr_wdata,
   input  logic                    mode_we,
   input  logic [CH_W-1:0]         mode_ch,
   input  logic                    mode_en,
   input  logic                    mode_above,
   output logic [RES_W-1:0]        thr_o,
   output ch_mode_t [NUM_CH-1:0]   mode_o
);

   logic [RES_W-1:0] thr_q;

   always_ff @(posedge clk) begin
      if (!rst_n)      thr_q <= '0;
      else if (thr_we) thr_q <= thr_wdata;
   end

   assign thr_o = thr_q;

   for (genvar c = 0; c < NUM_CH; c++) begin : g_mode
      ch_mode_t mode_q;
      always_ff @(posedge clk) begin
         if (!rst_n)
            mode_q <= MODE_RESET;
         else if (mode_we && (mode_ch == CH_W'(c)))
            mode_q <= '{en: mode_en, above: mode_above};
      end
      assign mode_o[c] = mode_q;

      // R11
      mode_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (mode_we && mode_ch == CH_W'(c)) |=> (mode_o[c].en == $past(mode_en)));
   end

   // R2
   thr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !thr_we |=> $stable(thr_o));

endmodule

// File: rtl/adc_cmp_chan.sv
module adc_cmp_chan
   import adc_cmp_pkg::*;
#(
   parameter int IDX   = 0,
   parameter int RES_W = 12,
   parameter int CH_W  = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             res_valid,
   input  logic [CH_W-1:0]  res_ch,
   input  logic [RES_W-1:0] res_val,
   input  logic [RES_W-1:0] thr,
   input  ch_mode_t         mode,
   input  logic             clr,
   output logic             irq_o,
   output logic             evt_o
);

   logic mine;
   logic meets;
   logic fire;

   assign mine  = res_valid && (res_ch == CH_W'(IDX));
   assign meets = mode.above ? (res_val >= thr) : (res_val < thr);
   assign fire  = mine && (!mode.en || meets);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         irq_o <= 1'b0;
         evt_o <= 1'b0;
      end else begin
         evt_o <= fire;
         if (fire)     irq_o <= 1'b1;
         else if (clr) irq_o <= 1'b0;
      end
   end

   // R6
   evt_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      evt_o |-> irq_o);

   // R7
   flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_o && !clr) |=> irq_o);

   // R10
   other_ch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && res_ch != CH_W'(IDX)) |=> !evt_o);

   // R5
   uncond_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mine && !mode.en) |=> (evt_o && irq_o));

   // R6
   no_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !mine |=> !evt_o);

endmodule

// File: rtl/adc_thresh_cmp.sv
module adc_thresh_cmp
   import adc_cmp_pkg::*;
#(
   parameter int NUM_CH         = 4,
   parameter int RES_W          = 12,
   parameter int NARROW_W       = 8,
   parameter bit NARROW_SUPPORT = 1'b1,
   localparam int CH_W          = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              thr_we,
   input  logic [RES_W-1:0]  thr_wdata,
   input  logic              mode_we,
   input  logic [CH_W-1:0]   mode_ch,
   input  logic              mode_en,
   input  logic              mode_above,
   input  logic              res_valid,
   input  logic [CH_W-1:0]   res_ch,
   input  logic              res_narrow,
   input  logic [RES_W-1:0]  res_data,
   input  logic [NUM_CH-1:0] irq_clr,
   output logic [NUM_CH-1:0] irq_flag,
   output logic [NUM_CH-1:0] evt_pulse
);

   if (NUM_CH < 1 || NUM_CH > 64) begin : g_bad_ch
      $error("NUM_CH out of range");
   end
   if (NARROW_W < 1 || NARROW_W >= RES_W) begin : g_bad_narrow
      $error("NARROW_W must be below RES_W");
   end

   logic [RES_W-1:0]      thr;
   ch_mode_t [NUM_CH-1:0] mode;
   logic [RES_W-1:0]      res_val;

   adc_cmp_cfg #(.NUM_CH(NUM_CH), .RES_W(RES_W)) u_cfg (
      .clk        (clk),
      .rst_n      (rst_n),
      .thr_we     (thr_we),
      .thr_wdata  (thr_wdata),
      .mode_we    (mode_we),
      .mode_ch    (mode_ch),
      .mode_en    (mode_en),
      .mode_above (mode_above),
      .thr_o      (thr),
      .mode_o     (mode)
   );

   if (NARROW_SUPPORT) begin : g_narrow
      assign res_val = res_narrow ? {{(RES_W-NARROW_W){1'b0}}, res_data[NARROW_W-1:0]}
                                  : res_data;
   end else begin : g_wide_only
      logic unused_narrow;
      assign unused_narrow = res_narrow;
      assign res_val = res_data;
   end

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      adc_cmp_chan #(.IDX(c), .RES_W(RES_W), .CH_W(CH_W)) u_chan (
         .clk       (clk),
         .rst_n     (rst_n),
         .res_valid (res_valid),
         .res_ch    (res_ch),
         .res_val   (res_val),
         .thr       (thr),
         .mode      (mode[c]),
         .clr       (irq_clr[c]),
         .irq_o     (irq_flag[c]),
         .evt_o     (evt_pulse[c])
      );
   end

   // R10
   one_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(evt_pulse));

   // R6
   evt_needs_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_pulse != '0) |-> $past(res_valid));

endmodule

// File: tb/tb_adc_thresh_cmp.sv
module tb_adc_thresh_cmp;

   localparam int NCH = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        thr_we = 1'b0;
   logic [11:0] thr_wdata = '0;
   logic        mode_we = 1'b0;
   logic [1:0]  mode_ch = '0;
   logic        mode_en = 1'b0;
   logic        mode_above = 1'b0;
   logic        res_valid = 1'b0;
   logic [1:0]  res_ch = '0;
   logic        res_narrow = 1'b0;
   logic [11:0] res_data = '0;
   logic [3:0]  irq_clr = '0;
   logic [3:0]  irq_flag;
   logic [3:0]  evt_pulse;

   always #2 clk = ~clk;

   adc_thresh_cmp dut (
      .clk(clk), .rst_n(rst_n), .thr_we(thr_we), .thr_wdata(thr_wdata),
      .mode_we(mode_we), .mode_ch(mode_ch), .mode_en(mode_en), .mode_above(mode_above),
      .res_valid(res_valid), .res_ch(res_ch), .res_narrow(res_narrow), .res_data(res_data),
      .irq_clr(irq_clr), .irq_flag(irq_flag), .evt_pulse(evt_pulse)
   );

   int checks = 0;
   int fails = 0;
   bit done = 1'b0;

   logic [11:0] m_thr;
   logic [3:0]  m_en, m_above, exp_irq, exp_evt;

   function automatic logic fires(logic [11:0] d, logic nar, logic en, logic ab, logic [11:0] t);
      logic [11:0] v;
      v = nar ? {4'h0, d[7:0]} : d;
      if (!en) return 1'b1;
      return ab ? (v >= t) : (v < t);
   endfunction

   task automatic check(string tag);
      checks++;
      if (irq_flag !== exp_irq || evt_pulse !== exp_evt) begin
         fails++;
         $display("FAIL %s: irq=%b evt=%b expected irq=%b evt=%b", tag,
                  irq_flag, evt_pulse, exp_irq, exp_evt);
      end
   endtask

   task automatic idle();
      thr_we = 0; mode_we = 0; res_valid = 0; res_narrow = 0; irq_clr = '0;
   endtask

   // apply the current inputs for one clock, update the model, check one stage later
   task automatic cycle(string tag);
      for (int c = 0; c < NCH; c++) begin
         logic h;
         h = res_valid && (res_ch == 2'(c)) &&
             fires(res_data, res_narrow, m_en[c], m_above[c], m_thr);
         exp_evt[c] = h;
         exp_irq[c] = h | (exp_irq[c] & ~irq_clr[c]);
      end
      if (thr_we) m_thr = thr_wdata;
      if (mode_we) begin
         m_en[mode_ch]    = mode_en;
         m_above[mode_ch] = mode_above;
      end
      @(posedge clk);
      @(negedge clk);
      check(tag);
      idle();
   endtask

   task automatic result(logic [1:0] ch, logic [11:0] d, logic nar);
      res_valid = 1; res_ch = ch; res_data = d; res_narrow = nar;
   endtask

   task automatic setmode(logic [1:0] ch, logic en, logic ab);
      mode_we = 1; mode_ch = ch; mode_en = en; mode_above = ab;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1;
         fails++;
         $display("FAIL watchdog: irq=%b evt=%b expected run to end", irq_flag, evt_pulse);
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd1234));
      m_thr = '0; m_en = '0; m_above = '0; exp_irq = '0; exp_evt = '0;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      check("R1 reset state");

      // R5 / R1: comparison disabled after reset, any value fires
      result(2'd0, 12'h005, 0); cycle("R5 disabled fires");
      cycle("R6 pulse ends");
      irq_clr = 4'b0001; cycle("R7 clear");
      result(2'd0, 12'h000, 0); irq_clr = 4'b0001; cycle("R7 set beats clear");
      irq_clr = 4'b0001; cycle("R7 clear again");

      // R2 / R11 / R3
      thr_we = 1; thr_wdata = 12'h800; setmode(2'd1, 1, 1); cycle("R2 R11 config");
      result(2'd1, 12'h800, 0); cycle("R3 equal fires");
      irq_clr = 4'b0010; cycle("R7 clear ch1");
      result(2'd1, 12'h7FF, 0); cycle("R3 below no fire");
      result(2'd1, 12'hFFF, 0); cycle("R3 max fires");
      irq_clr = 4'b0010; cycle("R7 clear ch1");

      // R4
      setmode(2'd2, 1, 0); cycle("R11 ch2 below");
      result(2'd2, 12'h800, 0); cycle("R4 equal no fire");
      result(2'd2, 12'h7FF, 0); cycle("R4 less fires");
      irq_clr = 4'b0100; cycle("R7 clear ch2");

      // R8
      thr_we = 1; thr_wdata = 12'h100; result(2'd1, 12'h200, 0); cycle("R8 old threshold");
      result(2'd1, 12'h200, 0); cycle("R2 new threshold");
      irq_clr = 4'b0010; cycle("R7 clear ch1");

      // R9
      result(2'd1, 12'hF80, 1); cycle("R9 narrow below");
      result(2'd1, 12'hF80, 0); cycle("R9 wide fires");
      result(2'd2, 12'hFFF, 1); cycle("R9 narrow ff below");
      irq_clr = 4'b0110; cycle("R7 clear");

      // R10 / R11 timing
      result(2'd3, 12'h000, 0); cycle("R10 ch3 only");
      setmode(2'd3, 1, 1); result(2'd3, 12'h000, 0); cycle("R11 old mode used");
      result(2'd3, 12'h000, 0); cycle("R11 new mode used");

      // random mix
      for (int i = 0; i < 3000; i++) begin
         thr_we    = ($urandom_range(7) == 0);
         thr_wdata = 12'($urandom);
         mode_we   = ($urandom_range(7) == 0);
         mode_ch   = 2'($urandom);
         mode_en   = ($urandom_range(3) != 0);
         mode_above = 1'($urandom);
         res_valid = 1'($urandom);
         res_ch    = 2'($urandom);
         res_narrow = ($urandom_range(3) == 0);
         res_data  = ($urandom_range(3) == 0) ? m_thr : 12'($urandom);
         irq_clr   = ($urandom_range(3) == 0) ? 4'($urandom) : 4'h0;
         cycle("R3 R4 R7 R8 R9 R10 random");
      end

      if (!done) begin
         done = 1;
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

endmodule